// File: doc/BRIEF.md
# 24-bit Accumulator Processor with Polled Byte Devices

This block is a small multicycle processor built around a 24-bit accumulator, a 24-bit index register and a 24-bit return-link register. It talks to a byte-wide synchronous memory with a 15-bit address. Each cycle it either asks for one byte or writes one byte. Reads have one cycle of latency: the byte asked for in one cycle is on `mem_rdata` in the next. Every instruction is three bytes long and is fetched one byte at a time. A data word is three bytes long, with the most significant byte at the lowest address.

The instruction set covers the following:
- word loads and stores of the three registers, plus single-byte load and store of the accumulator's low byte;
- two's-complement add and subtract;
- a signed compare that sets a three-way condition code, and jumps conditioned on that code;
- subroutine call and return;
- three device instructions. One polls a device's readiness into the condition code. The other two move a byte between the accumulator and the addressed device.

An opcode the block does not recognise stops it until the next reset.

Software reaches a device by repeating the readiness test until it reports ready, then issuing the read or write. The device number is the low byte of the instruction's target address.

Top module: `acc_cpu24`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears the accumulator, index, link and PC to zero and sets the condition code to "equal". During reset it shows a read request at address 0, with `halted` low and no write.
- R2: An instruction is three bytes, read from PC, PC+1 and PC+2. The first byte is the opcode. Bit 15 of the 24-bit instruction is the index flag, and bits 14:0 are the address field. PC grows by 3 once the third byte is taken.
- R3: The target address is the address field when the index flag is 0. When the flag is 1, it is the address field plus the low 15 bits of the index register. The sum wraps modulo 2^15.
- R4: Word loads read three bytes and word stores write three bytes, most significant byte at the target address. The opcodes are 0x00 (accumulator load), 0x04 (index load), 0x08 (link load), 0x0C (accumulator store), 0x10 (index store) and 0x14 (link store).
- R5: Opcode 0x50 replaces only the accumulator's low byte with the byte at the target address. Opcode 0x54 writes only the accumulator's low byte to the target address and leaves the neighbouring bytes unchanged.
- R6: Opcode 0x18 adds the memory word to the accumulator and opcode 0x1C subtracts it, both modulo 2^24. Neither changes the condition code.
- R7: Opcode 0x28 compares the accumulator with the memory word as signed 24-bit numbers. It sets the condition code to less, equal or greater and leaves the accumulator unchanged.
- R8: Opcodes 0x30 (on equal), 0x34 (on greater) and 0x38 (on less) load PC with the target address only when the condition code matches. Otherwise execution continues at the next instruction.
- R9: Opcode 0x48 stores the address of the following instruction in the link register and jumps to the target address. Opcode 0x4C jumps to the low 15 bits of the link register.
- R10: Opcode 0xE0 presents the low byte of the target address on `dev_sel`. It sets the condition code to less when `dev_ready` is high and to equal when it is low.
- R11: Opcode 0xD8 pulses `dev_rd` for one cycle and copies `dev_rdata` into the accumulator's low byte. Opcode 0xDC pulses `dev_wr` for one cycle with the accumulator's low byte on `dev_wdata`. The two pulses never occur together.
- R12: Any other opcode raises `halted`, which stays high until reset. While it is high there is no memory or device activity.
- R13: `mem_rd` and `mem_wr` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | 15 | Byte address for the current read or write |
| mem_rd | output | 1 | Read request; data is expected on `mem_rdata` next cycle |
| mem_wr | output | 1 | Write strobe for `mem_wdata` at `mem_addr` |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte returned for the previous cycle's read |
| dev_sel | output | 8 | Number of the addressed device |
| dev_rd | output | 1 | One-cycle device read strobe |
| dev_wr | output | 1 | One-cycle device write strobe |
| dev_wdata | output | 8 | Byte sent to the device |
| dev_ready | input | 1 | Readiness of the selected device |
| dev_rdata | input | 8 | Byte from the selected device |
| halted | output | 1 | High after an unknown opcode |

## Verification
Add, subtract and compare are each run through one fixed program from a vector table. The program stores the accumulator and then records which of the three conditional jumps was taken. The operands are chosen to expose an unsigned compare, a signed or carry overflow, a condition code wrongly updated by arithmetic, and an accumulator wrongly written by compare. Directed programs then check four things:
- indexed byte stores and the address wrap, using an index whose upper bits are set;
- call and return, using the stored link value;
- the test-poll-read-write device sequence against one device that is ready and one that is not;
- that the block stays quiet once halted.

// File: rtl/acc_cpu_pkg.sv
`timescale 1ns/1ps
// Package: shared opcode values, condition-code and sequencer state types
// for the accumulator processor. Assumes 8-bit opcodes.
package acc_cpu_pkg;
    localparam int OPC_W = 8;

    localparam logic [OPC_W-1:0] OP_LOAD_ACC  = 8'h00;
    localparam logic [OPC_W-1:0] OP_LOAD_IDX  = 8'h04;
    localparam logic [OPC_W-1:0] OP_LOAD_LNK  = 8'h08;
    localparam logic [OPC_W-1:0] OP_STOR_ACC  = 8'h0C;
    localparam logic [OPC_W-1:0] OP_STOR_IDX  = 8'h10;
    localparam logic [OPC_W-1:0] OP_STOR_LNK  = 8'h14;
    localparam logic [OPC_W-1:0] OP_ADD       = 8'h18;
    localparam logic [OPC_W-1:0] OP_SUB       = 8'h1C;
    localparam logic [OPC_W-1:0] OP_CMP       = 8'h28;
    localparam logic [OPC_W-1:0] OP_BR_EQ     = 8'h30;
    localparam logic [OPC_W-1:0] OP_BR_GT     = 8'h34;
    localparam logic [OPC_W-1:0] OP_BR_LT     = 8'h38;
    localparam logic [OPC_W-1:0] OP_CALL      = 8'h48;
    localparam logic [OPC_W-1:0] OP_RET       = 8'h4C;
    localparam logic [OPC_W-1:0] OP_LOAD_BYTE = 8'h50;
    localparam logic [OPC_W-1:0] OP_STOR_BYTE = 8'h54;
    localparam logic [OPC_W-1:0] OP_DEV_IN    = 8'hD8;
    localparam logic [OPC_W-1:0] OP_DEV_OUT   = 8'hDC;
    localparam logic [OPC_W-1:0] OP_DEV_POLL  = 8'hE0;

    typedef enum logic [1:0] {
        CC_EQ = 2'b00,
        CC_LT = 2'b01,
        CC_GT = 2'b10
    } cc_t;

    typedef enum logic [2:0] {
        S_FREQ,   // fetch: request instruction byte
        S_FCAP,   // fetch: capture instruction byte
        S_EXEC,   // decode / single-cycle execute
        S_RREQ,   // operand: request data byte
        S_RCAP,   // operand: capture data byte
        S_WRITE,  // store: write one byte per cycle
        S_HALT    // stopped on an unknown opcode
    } state_t;
endpackage

// File: rtl/acc_cpu_addr_gen.sv
`timescale 1ns/1ps
// Target-address generator: address field, optionally plus the index
// register's low bits. Assumes the sum wraps at the address width.
module acc_cpu_addr_gen #(
    parameter int ADDR_W = 15
) (
    input  logic [ADDR_W-1:0] field,
    input  logic              use_idx,
    input  logic [ADDR_W-1:0] idx_lo,
    output logic [ADDR_W-1:0] target
);
    // Add the index offset when the index flag is set; the carry out is dropped.
    always_comb begin
        target = field + (use_idx ? idx_lo : '0);
    end
endmodule

// File: rtl/acc_cpu_alu.sv
`timescale 1ns/1ps
// Arithmetic unit: add/subtract modulo 2^W and a signed three-way compare.
// Assumes two's-complement operands.
module acc_cpu_alu import acc_cpu_pkg::*; #(
    parameter int W = 24
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] result,
    output cc_t          rel
);
    // Sum or difference, truncated to W bits.
    always_comb begin
        result = sub ? (a - b) : (a + b);
    end

    // Signed relation of a to b.
    always_comb begin
        if ($signed(a) < $signed(b))      rel = CC_LT;
        else if (a == b)                  rel = CC_EQ;
        else                              rel = CC_GT;
    end
endmodule

// File: rtl/acc_cpu24.sv
`timescale 1ns/1ps
// Top: multicycle accumulator processor. Fetches 3-byte instructions a byte
// at a time from a synchronous memory with one cycle of read latency,
// executes word/byte moves, arithmetic, compare, jumps, call/return and
// polled device I/O. Assumes WORD_W = OPC_W + 1 + ADDR_W.
module acc_cpu24 import acc_cpu_pkg::*; #(
    parameter int WORD_W = 24,
    parameter int ADDR_W = 15,
    parameter int BYTE_W = 8,
    parameter int DEV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic [DEV_W-1:0]  dev_sel,
    output logic              dev_rd,
    output logic              dev_wr,
    output logic [BYTE_W-1:0] dev_wdata,
    input  logic              dev_ready,
    input  logic [BYTE_W-1:0] dev_rdata,
    output logic              halted
);
    localparam int WORD_BYTES = WORD_W / BYTE_W;
    localparam int CNT_W      = $clog2(WORD_BYTES);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_BYTES - 1);

    state_t                state;
    logic [CNT_W-1:0]      cnt;
    logic [WORD_W-1:0]     ir, acc, idx, lnk;
    logic [WORD_W-BYTE_W-1:0] dbuf;
    logic [ADDR_W-1:0]     pc;
    cc_t                   cc;

    logic [OPC_W-1:0]      op;
    logic [ADDR_W-1:0]     ta, cnt_ext;
    logic                  byte_op, last_byte;
    logic [WORD_W-1:0]     word_in, alu_res, src_word, src_shift;
    cc_t                   alu_rel;

    assign op      = ir[WORD_W-1 -: OPC_W];
    assign byte_op = (op == OP_LOAD_BYTE) || (op == OP_STOR_BYTE);
    assign cnt_ext = {{(ADDR_W-CNT_W){1'b0}}, cnt};
    assign word_in = {dbuf, mem_rdata};

    acc_cpu_addr_gen #(.ADDR_W(ADDR_W)) u_agen (
        .field   (ir[ADDR_W-1:0]),
        .use_idx (ir[ADDR_W]),
        .idx_lo  (idx[ADDR_W-1:0]),
        .target  (ta)
    );

    acc_cpu_alu #(.W(WORD_W)) u_alu (
        .a      (acc),
        .b      (word_in),
        .sub    (op == OP_SUB),
        .result (alu_res),
        .rel    (alu_rel)
    );

    // Last operand byte: one byte for byte ops, a full word otherwise.
    always_comb begin
        last_byte = byte_op ? (cnt == '0) : (cnt == CNT_LAST);
    end

    // Pick the register to store and align the current byte to the bottom.
    always_comb begin
        case (op)
            OP_STOR_IDX: src_word = idx;
            OP_STOR_LNK: src_word = lnk;
            default:     src_word = acc;
        endcase
        src_shift = src_word >> (BYTE_W * (WORD_BYTES - 1 - int'(cnt)));
    end

    // Memory and device port drive from the sequencer state.
    always_comb begin
        mem_rd    = (state == S_FREQ) || (state == S_RREQ);
        mem_wr    = (state == S_WRITE);
        mem_addr  = (state == S_FREQ) ? pc + cnt_ext : ta + cnt_ext;
        mem_wdata = byte_op ? acc[BYTE_W-1:0] : src_shift[BYTE_W-1:0];
        dev_sel   = ta[DEV_W-1:0];
        dev_rd    = (state == S_EXEC) && (op == OP_DEV_IN);
        dev_wr    = (state == S_EXEC) && (op == OP_DEV_OUT);
        dev_wdata = acc[BYTE_W-1:0];
        halted    = (state == S_HALT);
    end

    // Sequencer and architectural registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_FREQ;
            cnt   <= '0;
            ir    <= '0;
            dbuf  <= '0;
            acc   <= '0;
            idx   <= '0;
            lnk   <= '0;
            pc    <= '0;
            cc    <= CC_EQ;
        end else begin
            case (state)
                S_FREQ: state <= S_FCAP;
                S_FCAP: begin
                    ir <= {ir[WORD_W-BYTE_W-1:0], mem_rdata};
                    if (cnt == CNT_LAST) begin
                        cnt   <= '0;
                        pc    <= pc + ADDR_W'(WORD_BYTES);
                        state <= S_EXEC;
                    end else begin
                        cnt   <= cnt + 1'b1;
                        state <= S_FREQ;
                    end
                end
                S_EXEC: begin
                    state <= S_FREQ;
                    case (op)
                        OP_LOAD_ACC, OP_LOAD_IDX, OP_LOAD_LNK, OP_ADD,
                        OP_SUB, OP_CMP, OP_LOAD_BYTE:
                            state <= S_RREQ;
                        OP_STOR_ACC, OP_STOR_IDX, OP_STOR_LNK, OP_STOR_BYTE:
                            state <= S_WRITE;
                        OP_BR_EQ: if (cc == CC_EQ) pc <= ta;
                        OP_BR_GT: if (cc == CC_GT) pc <= ta;
                        OP_BR_LT: if (cc == CC_LT) pc <= ta;
                        OP_CALL: begin
                            lnk <= {{(WORD_W-ADDR_W){1'b0}}, pc};
                            pc  <= ta;
                        end
                        OP_RET:      pc <= lnk[ADDR_W-1:0];
                        OP_DEV_POLL: cc <= dev_ready ? CC_LT : CC_EQ;
                        OP_DEV_IN:   acc[BYTE_W-1:0] <= dev_rdata;
                        OP_DEV_OUT:  ;
                        default:     state <= S_HALT;
                    endcase
                end
                S_RREQ: state <= S_RCAP;
                S_RCAP: begin
                    dbuf <= word_in[WORD_W-BYTE_W-1:0];
                    if (last_byte) begin
                        cnt   <= '0;
                        state <= S_FREQ;
                        case (op)
                            OP_LOAD_ACC:  acc <= word_in;
                            OP_LOAD_IDX:  idx <= word_in;
                            OP_LOAD_LNK:  lnk <= word_in;
                            OP_ADD, OP_SUB: acc <= alu_res;
                            OP_CMP:       cc  <= alu_rel;
                            default:      acc[BYTE_W-1:0] <= mem_rdata;
                        endcase
                    end else begin
                        cnt   <= cnt + 1'b1;
                        state <= S_RREQ;
                    end
                end
                S_WRITE: begin
                    if (last_byte) begin
                        cnt   <= '0;
                        state <= S_FREQ;
                    end else begin
                        cnt   <= cnt + 1'b1;
                    end
                end
                default: state <= S_HALT;
            endcase
        end
    end

    // PC has moved one instruction on, the cycle after the last fetch byte.
    p_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_FCAP && cnt == CNT_LAST) |=> (pc == $past(pc) + ADDR_W'(WORD_BYTES)));

    // Device strobes are exclusive.
    p_dev_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(dev_rd && dev_wr));

    // Once stopped, the block stays stopped.
    p_halt_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    // No port activity while stopped.
    p_halt_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !(mem_rd || mem_wr || dev_rd || dev_wr));

    // Memory read and write never coincide.
    p_rdwr_excl_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));
endmodule

// File: tb/acc_cpu24_tb.sv
`timescale 1ns/1ps
module acc_cpu24_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [14:0] mem_addr;
    logic        mem_rd, mem_wr;
    logic [7:0]  mem_wdata, mem_rdata;
    logic [7:0]  dev_sel, dev_wdata, dev_rdata;
    logic        dev_rd, dev_wr, dev_ready;
    logic        halted;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    int overlap = 0;
    int dwr_n = 0, drd_n = 0;
    logic [7:0] dwr_sel, dwr_byte, drd_sel;
    logic [7:0] mem [0:4095];

    always #4 clk = ~clk;

    acc_cpu24 u_dut (
        .clk(clk), .rst_n(rst_n),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .dev_sel(dev_sel), .dev_rd(dev_rd), .dev_wr(dev_wr),
        .dev_wdata(dev_wdata), .dev_ready(dev_ready), .dev_rdata(dev_rdata),
        .halted(halted)
    );

    // Memory model: one-cycle read latency, byte write.
    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr[11:0]];
        if (mem_wr) mem[mem_addr[11:0]] <= mem_wdata;
    end

    // Device model: only device 0x05 is ready; it supplies 0xA5.
    assign dev_ready = (dev_sel == 8'h05);
    assign dev_rdata = 8'hA5;
    always @(posedge clk) begin
        if (dev_wr) begin dwr_n <= dwr_n + 1; dwr_sel <= dev_sel; dwr_byte <= dev_wdata; end
        if (dev_rd) begin drd_n <= drd_n + 1; drd_sel <= dev_sel; end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            fails = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic put_word(input int a, input logic [23:0] w);
        mem[a] = w[23:16]; mem[a+1] = w[15:8]; mem[a+2] = w[7:0];
    endtask

    function automatic logic [23:0] get_word(input int a);
        return {mem[a], mem[a+1], mem[a+2]};
    endfunction

    task automatic start_prog();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    endtask

    task automatic run_prog(input string tag);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 4000 && !halted; i++) begin
            @(negedge clk);
            if (mem_rd && mem_wr) overlap = overlap + 1;
        end
        chk({tag, " reaches halt R12"}, {31'd0, halted}, 32'd1);
    endtask

    // op, a, b, stored accumulator, flag (1=less,2=equal,3=greater jump taken)
    localparam logic [81:0] VEC [0:9] = '{
        {8'h18, 24'h000005, 24'h000007, 24'h00000C, 2'd2},
        {8'h18, 24'h7FFFFF, 24'h000001, 24'h800000, 2'd2},
        {8'h18, 24'hFFFFFF, 24'h000002, 24'h000001, 2'd2},
        {8'h1C, 24'h000003, 24'h000005, 24'hFFFFFE, 2'd2},
        {8'h1C, 24'h800000, 24'h000001, 24'h7FFFFF, 2'd2},
        {8'h28, 24'h000005, 24'h000007, 24'h000005, 2'd1},
        {8'h28, 24'h123456, 24'h123456, 24'h123456, 2'd2},
        {8'h28, 24'hFFFFFF, 24'h000001, 24'hFFFFFF, 2'd1},
        {8'h28, 24'h000001, 24'hFFFFFF, 24'h000001, 2'd3},
        {8'h28, 24'h7FFFFF, 24'h800000, 24'h7FFFFF, 2'd3}
    };

    initial begin
        int wr0, rd0, act;

        // R1: reset state shown at the ports.
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R1 reset read request", {31'd0, mem_rd}, 32'd1);
        chk("R1 reset address", {17'd0, mem_addr}, 32'd0);
        chk("R1 reset no write/halt", {30'd0, mem_wr, halted}, 32'd0);

        // Vector loop: R6 arithmetic, R7 compare, R8 conditional jumps.
        for (int v = 0; v < 10; v++) begin
            start_prog();
            put_word(16'h000, 24'h000200);
            put_word(16'h003, {VEC[v][81:74], 16'h0203});
            put_word(16'h006, 24'h0C0206);
            put_word(16'h009, 24'h380030);
            put_word(16'h00C, 24'h300040);
            put_word(16'h00F, 24'h340050);
            put_word(16'h012, 24'hFF0000);
            for (int k = 0; k < 3; k++) begin
                put_word(16'h030 + 16*k, 24'h040210 + 24'(3*k));
                put_word(16'h033 + 16*k, 24'h10020C);
                put_word(16'h036 + 16*k, 24'hFF0000);
                put_word(16'h210 + 3*k, 24'(k + 1));
            end
            put_word(16'h200, VEC[v][73:50]);
            put_word(16'h203, VEC[v][49:26]);
            run_prog("R2 vector");
            chk($sformatf("R6/R7 vector %0d accumulator", v),
                {8'd0, get_word(16'h206)}, {8'd0, VEC[v][25:2]});
            chk($sformatf("R8 vector %0d jump taken", v),
                {8'd0, get_word(16'h20C)}, {30'd0, VEC[v][1:0]});
        end

        // Directed: indexed byte store (R3, R5), call/return (R9), word store (R4).
        start_prog();
        put_word(16'h000, 24'h040210);
        put_word(16'h003, 24'h000213);
        put_word(16'h006, 24'h548300);
        put_word(16'h009, 24'h480060);
        put_word(16'h00C, 24'h140220);
        put_word(16'h00F, 24'hFF0000);
        put_word(16'h060, 24'h0C0230);
        put_word(16'h063, 24'h4C0000);
        put_word(16'h210, 24'h000005);
        put_word(16'h213, 24'h00ABCD);
        run_prog("R9 call");
        chk("R3/R5 indexed byte store", {24'd0, mem[16'h305]}, 32'h0000_00CD);
        chk("R5 byte store neighbours untouched", {16'd0, mem[16'h304], mem[16'h306]}, 32'd0);
        chk("R9 link holds return address", {8'd0, get_word(16'h220)}, 32'h0000_000C);
        chk("R4 word store inside subroutine", {8'd0, get_word(16'h230)}, 32'h0000_ABCD);

        // Directed: index wrap with upper index bits set (R3), link load, byte load (R5, R4).
        start_prog();
        put_word(16'h000, 24'h040210);
        put_word(16'h003, 24'h080213);
        put_word(16'h006, 24'h000213);
        put_word(16'h009, 24'h508217);
        put_word(16'h00C, 24'h0C0240);
        put_word(16'h00F, 24'h140250);
        put_word(16'h012, 24'h548105);
        put_word(16'h015, 24'h100260);
        put_word(16'h018, 24'hFF0000);
        put_word(16'h210, 24'hFF7FFF);
        put_word(16'h213, 24'h123456);
        mem[16'h216] = 8'h77;
        run_prog("R3 wrap");
        chk("R5 byte load keeps upper accumulator", {8'd0, get_word(16'h240)}, 32'h0012_3477);
        chk("R4 link load/store", {8'd0, get_word(16'h250)}, 32'h0012_3456);
        chk("R3 wrapped indexed byte store", {8'd0, mem[16'h103], mem[16'h104], mem[16'h105]},
            32'h0000_7700);
        chk("R4 index store", {8'd0, get_word(16'h260)}, 32'h00FF_7FFF);

        // Directed: device poll, read, write (R10, R11).
        start_prog();
        wr0 = dwr_n;
        rd0 = drd_n;
        put_word(16'h000, 24'hE00005);
        put_word(16'h003, 24'h380040);
        put_word(16'h006, 24'hFF0000);
        put_word(16'h040, 24'hD80005);
        put_word(16'h043, 24'hDC0009);
        put_word(16'h046, 24'hE00007);
        put_word(16'h049, 24'h300050);
        put_word(16'h04C, 24'hFF0000);
        put_word(16'h050, 24'h0C0240);
        put_word(16'h053, 24'hFF0000);
        run_prog("R10 device");
        chk("R10/R11 ready path and not-ready path reached", {8'd0, get_word(16'h240)},
            32'h0000_00A5);
        chk("R11 one write strobe", dwr_n - wr0, 32'd1);
        chk("R11 one read strobe", drd_n - rd0, 32'd1);
        chk("R11 write device and byte", {16'd0, dwr_sel, dwr_byte}, 32'h0000_09A5);
        chk("R10 read device number", {24'd0, drd_sel}, 32'h0000_0005);

        // R12: quiet and held after halting.
        act = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (mem_rd || mem_wr || dev_rd || dev_wr) act = act + 1;
        end
        chk("R12 no activity while halted", act, 32'd0);
        chk("R12 halt held", {31'd0, halted}, 32'd1);

        // R13: no cycle with both read and write across all runs.
        chk("R13 read/write overlap count", overlap, 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule